// File: doc/BRIEF.md
# TDMA Burst Timing Generator and Serializer

This block derives frame, timeslot and bit timing from a single-cycle enable that marks each period of a 13 MHz base clock. A bit lasts 48 base periods and a timeslot lasts 7500, which is 156.25 bit periods. Because of that fraction, the bit grid and the slot grid drift against each other and only realign every four slots. Eight slots make one frame.

In every slot that its mask enables, the block takes a parallel payload and sends it out one bit at a time as a 148-bit normal burst. The payload is two 57-bit data halves, two stealing flags and a 3-bit training-sequence code. The burst is placed at the first bit boundary at or after the slot boundary, and the rest of the slot is guard time with no strobe. Alongside the serial bit and its strobe, the block reports a ramp flag that covers the active part of the burst, a code for the kind of bit being sent, and the current slot and frame numbers. It sits between a burst-building stage and the transmit modulator.

Top module: `tdma_burst_gen`

## Requirements
- R1: While `rst_n` is low, and right after it rises, these outputs are all zero: `bit_out`, `bit_vld`, `ramp_on`, `seg_kind`, `slot_num` and `frame_num`.
- R2: All counters advance only on clock cycles where `tick_en` is high. No strobe is issued and no output changes while `tick_en` stays low. Tick number n is the n-th high `tick_en` since reset, counting from 0.
- R3: `slot_num` increments after every 7500 ticks and wraps from 7 to 0. `frame_num` increments on that wrap, modulo 2^FN_W. Both are updated on tick 7500k-1, so tick 7500k already sees the new values.
- R4: A burst in absolute slot a starts at tick S = 48*ceil(7500a/48), which is the first multiple of 48 at or after the slot boundary. It issues exactly 148 one-cycle `bit_vld` strobes, on ticks S + 48i for i = 0..147.
- R5: Bit order in the burst, with index 0 sent first: 3 zero tail bits, then `data_a` from bit 56 down to bit 0, then `steal_a`, then the 26 training bits from the most significant bit down, then `steal_b`, then `data_b` from bit 56 down to bit 0, then 3 zero tail bits.
- R6: `tsc_sel` = k selects a 26-bit training pattern. The patterns for k = 0..7 are 0x0970897, 0x0B778B7, 0x10EE90E, 0x11ED11E, 0x06B906B, 0x13AC13A, 0x29F629F and 0x3BC4BBC.
- R7: `slot_mask` bit s, where s is the slot number, is sampled on the tick where the slot begins. If that bit is 0, the slot gives no strobes and `ramp_on` stays low throughout it.
- R8: `ramp_on` goes high on burst tick S and stays high for exactly 148*48 ticks.
- R9: `seg_kind` describes the bit currently being sent and holds that value for the whole bit period. The codes are: 1 = tail (indices 0-2 and 145-147), 3 = training (indices 61-86), 2 = data or stealing flag (all other indices), and 0 = guard, which applies whenever `ramp_on` is low.
- R10: All payload inputs are sampled on the first bit's tick. Changes to them after that tick have no effect on the burst in progress.
- R11: Outside the burst, which is the guard period and any disabled slot, `bit_vld` and `bit_out` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Enable marking one base period |
| slot_mask | input | SLOTS | Per-slot burst enable |
| data_a | input | 57 | First data half |
| data_b | input | 57 | Second data half |
| steal_a | input | 1 | Stealing flag after the first half |
| steal_b | input | 1 | Stealing flag before the second half |
| tsc_sel | input | 3 | Training pattern select |
| bit_out | output | 1 | Serial burst bit |
| bit_vld | output | 1 | One-cycle strobe marking a new bit |
| ramp_on | output | 1 | High during the active part of the burst |
| seg_kind | output | 2 | Kind of the current bit |
| slot_num | output | SLOT_W | Current timeslot |
| frame_num | output | FN_W | Frame counter |

## Verification
The embedded properties hold on every cycle for these behaviours:
- a strobe only ever falls inside the ramp window, and strobes are never back to back;
- the guard code holds whenever the ramp flag is low;
- the slot number only ever steps forward by one;
- nothing moves on a cycle without a tick.

Other behaviours need the bench's cycle-exact reference, which follows twelve consecutive slots: the drifting start offsets of 0, 36, 24 and 12 ticks, the exact bit contents for every training code, masked slots, and payload changes made mid-burst. A separate scenario with ticks on alternate cycles shows that the timing counts ticks rather than clock cycles.

// File: rtl/tdma_burst_gen.sv
module tdma_burst_gen #(
  parameter int TICKS_PER_BIT  = 48,
  parameter int TICKS_PER_SLOT = 7500,
  parameter int SLOTS          = 8,
  parameter int FN_W           = 11
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tick_en,
  input  logic [SLOTS-1:0]            slot_mask,
  input  logic [56:0]                 data_a,
  input  logic [56:0]                 data_b,
  input  logic                        steal_a,
  input  logic                        steal_b,
  input  logic [2:0]                  tsc_sel,
  output logic                        bit_out,
  output logic                        bit_vld,
  output logic                        ramp_on,
  output logic [1:0]                  seg_kind,
  output logic [$clog2(SLOTS)-1:0]    slot_num,
  output logic [FN_W-1:0]             frame_num
);
  localparam int TCW        = $clog2(TICKS_PER_SLOT);
  localparam int BPW        = $clog2(TICKS_PER_BIT);
  localparam int SLOT_W     = $clog2(SLOTS);
  localparam int TAIL       = 3;
  localparam int HALF       = 57;
  localparam int TRAIN      = 26;
  localparam int BURST_BITS = 2*TAIL + 2*HALF + 2 + TRAIN;
  localparam int IDXW       = $clog2(BURST_BITS + 1);
  localparam int TRAIN_LO   = TAIL + HALF + 1;
  localparam int TRAIN_HI   = TRAIN_LO + TRAIN;
  localparam int TAIL_LO    = BURST_BITS - TAIL;

  localparam logic [1:0] K_GUARD = 2'd0;
  localparam logic [1:0] K_TAIL  = 2'd1;
  localparam logic [1:0] K_DATA  = 2'd2;
  localparam logic [1:0] K_TRAIN = 2'd3;

  function automatic logic [TRAIN-1:0] train_pat(input logic [2:0] k);
    case (k)
      3'd0:    train_pat = 26'h0970897;
      3'd1:    train_pat = 26'h0B778B7;
      3'd2:    train_pat = 26'h10EE90E;
      3'd3:    train_pat = 26'h11ED11E;
      3'd4:    train_pat = 26'h06B906B;
      3'd5:    train_pat = 26'h13AC13A;
      3'd6:    train_pat = 26'h29F629F;
      default: train_pat = 26'h3BC4BBC;
    endcase
  endfunction

  function automatic logic [1:0] kind_of(input logic [IDXW-1:0] i);
    if (i < IDXW'(TAIL) || i >= IDXW'(TAIL_LO))                  kind_of = K_TAIL;
    else if (i >= IDXW'(TRAIN_LO) && i < IDXW'(TRAIN_HI))        kind_of = K_TRAIN;
    else                                                         kind_of = K_DATA;
  endfunction

  logic [TCW-1:0]        tcnt;
  logic [BPW-1:0]        bph;
  logic [SLOT_W-1:0]     slot_q;
  logic [FN_W-1:0]       frame_q;
  logic                  pend, active;
  logic [IDXW-1:0]       bidx;
  logic [BURST_BITS-1:0] shreg;
  logic [1:0]            seg_q;

  wire slot_edge = (tcnt == '0);
  wire bit_edge  = (bph == '0);
  wire slot_last = (tcnt == TCW'(TICKS_PER_SLOT-1));
  wire want      = pend | (slot_edge & slot_mask[slot_q]);
  wire start     = tick_en & want & bit_edge & ~active;

  wire [BURST_BITS-1:0] vec = {{TAIL{1'b0}}, data_a, steal_a, train_pat(tsc_sel),
                               steal_b, data_b, {TAIL{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt    <= '0;
      bph     <= '0;
      slot_q  <= '0;
      frame_q <= '0;
    end else if (tick_en) begin
      tcnt <= slot_last ? '0 : tcnt + 1'b1;
      bph  <= (bph == BPW'(TICKS_PER_BIT-1)) ? '0 : bph + 1'b1;
      if (slot_last) begin
        slot_q <= (slot_q == SLOT_W'(SLOTS-1)) ? '0 : slot_q + 1'b1;
        if (slot_q == SLOT_W'(SLOTS-1)) frame_q <= frame_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      active  <= 1'b0;
      bidx    <= '0;
      shreg   <= '0;
      seg_q   <= K_GUARD;
      bit_out <= 1'b0;
      bit_vld <= 1'b0;
    end else begin
      bit_vld <= 1'b0;
      if (tick_en) begin
        if (start) begin
          active  <= 1'b1;
          pend    <= 1'b0;
          shreg   <= {vec[BURST_BITS-2:0], 1'b0};
          bit_out <= vec[BURST_BITS-1];
          bit_vld <= 1'b1;
          bidx    <= IDXW'(1);
          seg_q   <= K_TAIL;
        end else if (slot_edge && slot_mask[slot_q] && !bit_edge) begin
          pend <= 1'b1;
        end else if (active && bit_edge) begin
          if (bidx == IDXW'(BURST_BITS)) begin
            active  <= 1'b0;
            bit_out <= 1'b0;
            seg_q   <= K_GUARD;
            bidx    <= '0;
          end else begin
            bit_out <= shreg[BURST_BITS-1];
            shreg   <= {shreg[BURST_BITS-2:0], 1'b0};
            bit_vld <= 1'b1;
            seg_q   <= kind_of(bidx);
            bidx    <= bidx + 1'b1;
          end
        end
      end
    end
  end

  assign ramp_on   = active;
  assign seg_kind  = seg_q;
  assign slot_num  = slot_q;
  assign frame_num = frame_q;

  p_strobe_in_ramp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |-> ramp_on);
  p_strobe_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |=> !bit_vld);
  p_guard_kind_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ramp_on |-> (seg_kind == K_GUARD && !bit_vld && !bit_out));
  p_slot_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_num != $past(slot_num)) |-> (slot_num == SLOT_W'($past(slot_num) + 1'b1)));
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> (!bit_vld && $stable(slot_num) && $stable(ramp_on) && $stable(bit_out)));
  p_burst_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bidx <= IDXW'(BURST_BITS));
endmodule

// File: tb/tdma_burst_gen_tb.sv
module tdma_burst_gen_tb;
  localparam int TPB = 48;
  localparam int TPS = 7500;
  localparam int NSLOT = 12;

  // entry: en, tsc[2:0], steal_a, steal_b, seed_a[15:0], seed_b[15:0]
  localparam logic [37:0] VEC [NSLOT] = '{
    {1'b1, 3'd0, 1'b1, 1'b0, 16'hA5C3, 16'h1234},
    {1'b1, 3'd1, 1'b0, 1'b1, 16'hFFFF, 16'h0000},
    {1'b0, 3'd2, 1'b1, 1'b1, 16'h5555, 16'hAAAA},
    {1'b1, 3'd2, 1'b1, 1'b1, 16'h0F0F, 16'hF0F0},
    {1'b1, 3'd3, 1'b0, 1'b0, 16'h8001, 16'h7FFE},
    {1'b1, 3'd4, 1'b1, 1'b0, 16'hDEAD, 16'hBEEF},
    {1'b0, 3'd5, 1'b0, 1'b1, 16'h1111, 16'h2222},
    {1'b1, 3'd5, 1'b0, 1'b1, 16'hC0DE, 16'hFACE},
    {1'b1, 3'd6, 1'b1, 1'b1, 16'h3C3C, 16'h6969},
    {1'b0, 3'd7, 1'b0, 1'b0, 16'h4242, 16'h2424},
    {1'b1, 3'd7, 1'b1, 1'b0, 16'h9876, 16'h5432},
    {1'b1, 3'd3, 1'b0, 1'b1, 16'h0001, 16'h8000}
  };

  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0;
  logic [7:0] slot_mask = '0;
  logic [56:0] data_a = '0, data_b = '0;
  logic steal_a = 1'b0, steal_b = 1'b0;
  logic [2:0] tsc_sel = '0;
  logic bit_out, bit_vld, ramp_on;
  logic [1:0] seg_kind;
  logic [2:0] slot_num;
  logic [10:0] frame_num;
  int nchk = 0, nfail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  tdma_burst_gen u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .slot_mask(slot_mask),
    .data_a(data_a), .data_b(data_b), .steal_a(steal_a), .steal_b(steal_b),
    .tsc_sel(tsc_sel), .bit_out(bit_out), .bit_vld(bit_vld), .ramp_on(ramp_on),
    .seg_kind(seg_kind), .slot_num(slot_num), .frame_num(frame_num));

  function automatic logic [25:0] tpat(input logic [2:0] k);
    logic [25:0] t [8] = '{26'h0970897, 26'h0B778B7, 26'h10EE90E, 26'h11ED11E,
                           26'h06B906B, 26'h13AC13A, 26'h29F629F, 26'h3BC4BBC};
    return t[k];
  endfunction

  function automatic logic [56:0] spread(input logic [15:0] s);
    return {s, s ^ 16'h5A5A, ~s, s[8:0]};
  endfunction

  function automatic logic [147:0] burst_of(input int e);
    logic [37:0] v = VEC[e];
    return {3'b000, spread(v[31:16]), v[33], tpat(v[36:34]), v[32], spread(v[15:0]), 3'b000};
  endfunction

  function automatic logic [1:0] kind_at(input int i);
    if (i < 3 || i >= 145) return 2'd1;
    if (i >= 61 && i < 87) return 2'd3;
    return 2'd2;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual=%0d expected=%0d (time %0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic drive_entry(input int e, input bit scramble);
    logic [37:0] v = VEC[e];
    int s = e % 8;
    slot_mask = v[37] ? 8'(1 << s) : ~8'(1 << s);
    tsc_sel   = v[36:34];
    steal_a   = v[33];
    steal_b   = v[32];
    data_a    = spread(v[31:16]);
    data_b    = spread(v[15:0]);
    if (scramble) begin
      tsc_sel = ~tsc_sel; steal_a = ~steal_a; steal_b = ~steal_b;
      data_a = ~data_a; data_b = ~data_b;
    end
  endtask

  task automatic check_tick(input int n);
    int a = n / TPS;
    int st = ((TPS * a + TPB - 1) / TPB) * TPB;
    bit en = VEC[a][37];
    bit eramp = en && n >= st && n < st + 148 * TPB;
    bit evld = eramp && ((n - st) % TPB == 0);
    int idx = eramp ? (n - st) / TPB : 0;
    logic [147:0] bv = burst_of(a);
    int ekind = eramp ? int'(kind_at(idx)) : 0;
    int eslot = ((n + 1) / TPS) % 8;
    int efr = (n + 1) / (8 * TPS);
    // R3 slot and frame numbering
    chk(slot_num == 3'(eslot), "R3", "slot_num", slot_num, eslot);
    chk(frame_num == 11'(efr), "R3", "frame_num", frame_num, efr);
    // R4 strobe timing, R7 mask
    chk(bit_vld == evld, en ? "R4" : "R7", "bit_vld", bit_vld, evld);
    // R8 ramp window
    chk(ramp_on == eramp, en ? "R8" : "R7", "ramp_on", ramp_on, eramp);
    // R9 segment code
    chk(seg_kind == 2'(ekind), "R9", "seg_kind", seg_kind, ekind);
    if (evld) begin
      // R5 bit order, R6 training table, R10 payload latched at first bit
      chk(bit_out == bv[147 - idx], (idx >= 61 && idx < 87) ? "R6" : (idx > 0 ? "R10" : "R5"),
          "bit_out", bit_out, bv[147 - idx]);
    end
    if (!eramp) chk(bit_out == 1'b0, "R11", "bit_out in guard", bit_out, 0);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    drive_entry(0, 1'b0);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({bit_out, bit_vld, ramp_on} == 3'b000 && seg_kind == 2'd0 && slot_num == 3'd0 && frame_num == '0,
        "R1", "outputs in reset", {bit_out, bit_vld, ramp_on}, 0);
    rst_n = 1'b1;
    tick_en = 1'b1;
    for (int n = 0; n < NSLOT * TPS; n++) begin
      @(posedge clk);
      @(negedge clk);
      check_tick(n);
      begin
        int a = n / TPS;
        int st = ((TPS * a + TPB - 1) / TPB) * TPB;
        if (n == st) drive_entry(a, 1'b1);
        if ((n + 1) % TPS == 0 && (n + 1) / TPS < NSLOT) drive_entry((n + 1) / TPS, 1'b0);
      end
    end

    // R1 reset again mid-operation
    tick_en = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(!bit_vld && !ramp_on && slot_num == 0 && frame_num == 0 && seg_kind == 0,
        "R1", "outputs after re-reset", ramp_on, 0);
    drive_entry(0, 1'b0);
    rst_n = 1'b1;
    // R2 no tick -> nothing moves
    begin
      int seen = 0;
      for (int c = 0; c < 200; c++) begin
        @(negedge clk);
        if (bit_vld || ramp_on || slot_num != 0) seen++;
      end
      chk(seen == 0, "R2", "activity without tick", seen, 0);
    end
    // R2 ticks on alternate cycles: 100 ticks -> strobes at ticks 0, 48, 96
    begin
      int strobes = 0;
      for (int c = 0; c < 200; c++) begin
        tick_en = (c % 2 == 0);
        @(negedge clk);
        if (bit_vld) strobes++;
      end
      tick_en = 1'b0;
      chk(strobes == 3, "R2", "strobes with half-rate ticks", strobes, 3);
      chk(ramp_on == 1'b1, "R2", "ramp after 100 ticks", ramp_on, 1);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule